// File: doc/BRIEF.md
# Function Unit Ordering Matrix

This block keeps the program order of in-flight operations as a square grid of single-bit cells, one row and one column per function unit. A set cell means that the row unit has to wait for the column unit. The cells form a directed acyclic graph, a hardware linked list, so no reorder-buffer number is kept. Units are named in unary: bit `i` of every vector port stands for unit `i`.

There are two bit planes. In the write-wait plane, a row unit waits for a column unit to write its result before the row unit may read operands. In the read-wait plane, a row unit waits for a column unit to read its operands before the row unit may write. When a unit issues, the caller gives two hazard vectors. The block loads them into the issuing unit's row, keeping only units that are busy. A unit's readiness is the NOR of its row in each plane, and the block presents it on registered outputs. Read and write grants clear the granted unit's column. A unit reset, or a completed write, also clears the unit's row and its busy state.

Top module: `fu_order_matrix`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every cell is clear, no unit is busy, and `rd_ok_o` and `wr_ok_o` are all ones.
- R2: On issue of unit u, row u of the write-wait plane takes `wr_wait_i` limited to busy units. `rd_ok_o[u]` is low from the next cycle while any such cell remains set.
- R3: On issue of unit u, row u of the read-wait plane takes `rd_wait_i` limited to busy units. `wr_ok_o[u]` is low from the next cycle while any such cell remains set.
- R4: A unit never records a dependency on itself, even when its own bit is set in a hazard vector.
- R5: Hazard bits that name units which are not busy are ignored.
- R6: `go_rd_i[c]` clears column c of the read-wait plane only.
- R7: `go_wr_i[c]` clears column c in both planes, clears row c in both planes, and ends the busy state of unit c.
- R8: `fu_rst_i[c]` has the same effect as `go_wr_i[c]`.
- R9: A dependency on a unit whose column is cleared in the same cycle as the issue is not recorded.
- R10: A strobe shows on `rd_ok_o` and `wr_ok_o` after exactly one clock edge. With no strobe, both outputs hold.
- R11: Issue makes the unit busy. A row clear for the same unit in the same cycle takes priority over issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | NUM_FU | One-hot issuing unit |
| wr_wait_i | input | NUM_FU | Units whose result the issuer must wait for before reading |
| rd_wait_i | input | NUM_FU | Units whose operand read must precede the issuer's write |
| go_rd_i | input | NUM_FU | Read grant per unit |
| go_wr_i | input | NUM_FU | Write grant (completion) per unit |
| fu_rst_i | input | NUM_FU | Per-unit cancel |
| rd_ok_o | output | NUM_FU | Unit may read operands |
| wr_ok_o | output | NUM_FU | Unit may write its result |

## Verification
The bench builds the block with NUM_FU = 5. This is enough units for a chain of three dependents, idle units named in hazard vectors, and self bits, while the random stream still often fills every unit. An odd count also keeps any power-of-two assumption in the row or column indexing from going unnoticed. Directed steps cover a clear in the same cycle as an issue and a cancel in the middle of a chain. The random stream often issues, grants and cancels in the same cycle.

// File: rtl/fu_order_pkg.sv
package fu_order_pkg;
  typedef enum int unsigned {
    PLANE_WR = 0,
    PLANE_RD = 1
  } plane_e;
  localparam int unsigned NUM_PLANES = 2;
endpackage

// File: rtl/fu_busy_track.sv
module fu_busy_track #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] busy_o
);
  logic [N-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= (busy_q | set_i) & ~clr_i;
  end

  assign busy_o = busy_q;

  for (genvar u = 0; u < N; u++) begin : g_chk
    // R11
    busy_clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
      clr_i[u] |=> !busy_o[u]);
    // R11
    busy_on_issue_chk: assert property (@(posedge clk) disable iff (rst)
      (set_i[u] && !clr_i[u]) |=> busy_o[u]);
  end
endmodule

// File: rtl/fu_dep_plane.sv
module fu_dep_plane #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] issue_i,
  input  logic [N-1:0] load_i,
  input  logic [N-1:0] col_clr_i,
  input  logic [N-1:0] row_clr_i,
  output logic [N-1:0] free_nxt_o
);
  logic [N-1:0] cell_q [N];
  logic [N-1:0] cell_d [N];
  logic [N-1:0] col_t  [N];

  for (genvar r = 0; r < N; r++) begin : g_row
    localparam logic [N-1:0] SELF = N'(1) << r;

    always_comb begin
      if (row_clr_i[r])     cell_d[r] = '0;
      else if (issue_i[r])  cell_d[r] = load_i & ~col_clr_i & ~SELF;
      else                  cell_d[r] = cell_q[r] & ~col_clr_i;
    end

    always_ff @(posedge clk) begin
      if (rst) cell_q[r] <= '0;
      else     cell_q[r] <= cell_d[r];
    end

    assign free_nxt_o[r] = ~|cell_d[r];

    for (genvar c = 0; c < N; c++) begin : g_t
      assign col_t[c][r] = cell_q[r][c];
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_col_chk
    // R9
    col_cleared_chk: assert property (@(posedge clk) disable iff (rst)
      col_clr_i[c] |=> (col_t[c] == '0));
    // R4
    no_self_dep_chk: assert property (@(posedge clk) disable iff (rst)
      issue_i[c] |=> !col_t[c][c]);
  end
endmodule

// File: rtl/fu_order_matrix.sv
module fu_order_matrix
  import fu_order_pkg::*;
#(
  parameter int unsigned NUM_FU = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_FU-1:0] issue_i,
  input  logic [NUM_FU-1:0] wr_wait_i,
  input  logic [NUM_FU-1:0] rd_wait_i,
  input  logic [NUM_FU-1:0] go_rd_i,
  input  logic [NUM_FU-1:0] go_wr_i,
  input  logic [NUM_FU-1:0] fu_rst_i,
  output logic [NUM_FU-1:0] rd_ok_o,
  output logic [NUM_FU-1:0] wr_ok_o
);
  localparam int unsigned N = NUM_FU;

  logic [N-1:0] busy;
  logic [N-1:0] done;
  logic [N-1:0] load_a [NUM_PLANES];
  logic [N-1:0] clr_a  [NUM_PLANES];
  logic [N-1:0] free_a [NUM_PLANES];
  logic [N-1:0] rd_ok_q, wr_ok_q;

  assign done = go_wr_i | fu_rst_i;

  fu_busy_track #(.N(N)) u_busy (
    .clk(clk), .rst(rst), .set_i(issue_i), .clr_i(done), .busy_o(busy)
  );

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    if (p == PLANE_WR) begin : g_wr
      assign load_a[p] = wr_wait_i & busy;
      assign clr_a[p]  = done;
    end else begin : g_rd
      assign load_a[p] = rd_wait_i & busy;
      assign clr_a[p]  = done | go_rd_i;
    end

    fu_dep_plane #(.N(N)) u_plane (
      .clk(clk), .rst(rst), .issue_i(issue_i), .load_i(load_a[p]),
      .col_clr_i(clr_a[p]), .row_clr_i(done), .free_nxt_o(free_a[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_q <= '1;
      wr_ok_q <= '1;
    end else begin
      rd_ok_q <= free_a[PLANE_WR];
      wr_ok_q <= free_a[PLANE_RD];
    end
  end

  assign rd_ok_o = rd_ok_q;
  assign wr_ok_o = wr_ok_q;

  // R11
  single_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue_i));
  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_i == '0 && go_rd_i == '0 && done == '0) |=>
      ($stable(rd_ok_o) && $stable(wr_ok_o)));

  for (genvar u = 0; u < N; u++) begin : g_chk
    // R8
    unit_rst_ready_chk: assert property (@(posedge clk) disable iff (rst)
      fu_rst_i[u] |=> (rd_ok_o[u] && wr_ok_o[u]));
    // R5
    idle_issue_ready_chk: assert property (@(posedge clk) disable iff (rst)
      (issue_i[u] && busy == '0) |=> (rd_ok_o[u] && wr_ok_o[u]));
  end
endmodule

// File: tb/fu_order_matrix_test.sv
module fu_order_matrix_test;
  localparam int N = 5;

  logic clk = 0, rst = 1;
  logic [N-1:0] issue_i = '0, wr_wait_i = '0, rd_wait_i = '0;
  logic [N-1:0] go_rd_i = '0, go_wr_i = '0, fu_rst_i = '0;
  logic [N-1:0] rd_ok_o, wr_ok_o;

  int vectors = 0, fails = 0;
  logic [N-1:0] mw [N];
  logic [N-1:0] mr [N];
  logic [N-1:0] mbusy;

  always #5 clk = ~clk;

  fu_order_matrix #(.NUM_FU(N)) uut (.*);

  function automatic logic [N-1:0] exp_rd();
    logic [N-1:0] v;
    for (int r = 0; r < N; r++) v[r] = ~|mw[r];
    return v;
  endfunction

  function automatic logic [N-1:0] exp_wr();
    logic [N-1:0] v;
    for (int r = 0; r < N; r++) v[r] = ~|mr[r];
    return v;
  endfunction

  task automatic model_step();
    logic [N-1:0] cw, cr, ob;
    cw = go_wr_i | fu_rst_i;
    cr = cw | go_rd_i;
    ob = mbusy;
    for (int r = 0; r < N; r++) begin
      logic [N-1:0] self;
      self = N'(1) << r;
      if (cw[r]) begin
        mw[r] = '0; mr[r] = '0;
      end else if (issue_i[r]) begin
        mw[r] = wr_wait_i & ob & ~cw & ~self;
        mr[r] = rd_wait_i & ob & ~cr & ~self;
      end else begin
        mw[r] = mw[r] & ~cw;
        mr[r] = mr[r] & ~cr;
      end
    end
    mbusy = (ob | issue_i) & ~cw;
  endtask

  task automatic check(string tag);
    vectors++;
    if (rd_ok_o !== exp_rd()) begin
      fails++;
      $display("FAIL %s rd_ok got %b exp %b", tag, rd_ok_o, exp_rd());
    end
    if (wr_ok_o !== exp_wr()) begin
      fails++;
      $display("FAIL %s wr_ok got %b exp %b", tag, wr_ok_o, exp_wr());
    end
  endtask

  task automatic apply(logic [N-1:0] iss, logic [N-1:0] ww, logic [N-1:0] rw,
                       logic [N-1:0] gr, logic [N-1:0] gw, logic [N-1:0] fr,
                       string tag);
    issue_i = iss; wr_wait_i = ww; rd_wait_i = rw;
    go_rd_i = gr; go_wr_i = gw; fu_rst_i = fr;
    model_step();
    @(posedge clk);
    @(negedge clk);
    issue_i = '0; wr_wait_i = '0; rd_wait_i = '0;
    go_rd_i = '0; go_wr_i = '0; fu_rst_i = '0;
    check(tag);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < N; r++) begin mw[r] = '0; mr[r] = '0; end
    mbusy = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 during reset");
    rst = 0;
    @(negedge clk);
    check("R1 after reset");

    apply(5'b00001, '0, '0, '0, '0, '0, "R11 issue idle unit0");
    apply(5'b00010, 5'b00001, 5'b00001, '0, '0, '0, "R2 R3 unit1 waits on unit0");
    apply('0, '0, '0, '0, '0, '0, "R10 hold with no strobe");
    apply('0, '0, '0, 5'b00001, '0, '0, "R6 read grant unit0");
    apply(5'b00100, 5'b01101, 5'b01100, '0, '0, '0, "R4 R5 self and idle bits");
    apply('0, '0, '0, '0, 5'b00001, '0, "R7 write grant unit0");
    apply(5'b01000, 5'b00110, '0, '0, 5'b00010, '0, "R9 issue with same-cycle clear");
    apply(5'b10000, '0, 5'b01100, '0, '0, '0, "R3 unit4 waits reads");
    apply('0, '0, '0, '0, '0, 5'b00100, "R8 cancel unit2");
    apply(5'b00010, '0, '0, '0, '0, 5'b00010, "R11 clear beats issue");
    apply('0, '0, '0, '0, '0, '1, "R8 cancel all");

    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] iss, gr, gw, fr;
      iss = '0;
      if ($urandom_range(1, 0) == 1) begin
        int u;
        u = $urandom_range(N - 1, 0);
        if (!mbusy[u]) iss = N'(1) << u;
      end
      gr = N'($urandom) & mbusy;
      gw = ($urandom_range(3, 0) == 0) ? (N'($urandom) & mbusy) : '0;
      fr = ($urandom_range(15, 0) == 0) ? N'($urandom) : '0;
      apply(iss, N'($urandom), N'($urandom), gr, gw, fr, "R2 R3 R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule